// File: doc/BRIEF.md
# SPI Framed Register-Access Bridge

This block is an SPI target that turns framed transactions from an SPI host into accesses on a simple parallel register port. The system clock oversamples the SPI lines, so one clock domain serves the whole block. A frame opens when chip select goes low. The first byte is a header that gives the direction and a length of 1 to 64 bytes. Three address bytes follow, then the data bytes.

Write data is collected in a 64-byte buffer and committed to the port once the last byte has arrived. A read is fetched from the port right after the third address byte, and the fetched bytes are then shifted back to the host. Accesses whose low address bits hit the data-FIFO offset become a run of single-byte port accesses. Any other address gets one access that carries the whole length.

The target answers each received byte with a response byte, and that response goes out during the following SPI byte. An optional pre-read mode inserts one extra read step when the read-data phase starts, so that read data leaves one byte earlier.

Top module: `spi_regbridge`

## Requirements
- R1: The header byte carries the direction in bit 7 (1 = read, 0 = write) and the length minus one in bits [5:0]. Bit 6 has no effect on the transaction.
- R2: Exactly three address bytes follow the header, most significant first, and together they form the 24-bit `port_addr` of every access in the frame.
- R3: For a write, no port access occurs before the last data byte has been received. A non-FIFO write is then one access with `port_size` equal to the length and data byte k in `port_wdata[8k+7:8k]`, for k below 4; the remaining bits are zero.
- R4: When `(addr & 0xFFC) == 0x024`, the frame uses N separate accesses with `port_size` = 1, all to the same address and in byte order. A FIFO write carries its byte in `port_wdata[7:0]`.
- R5: A read issues its port access(es) after the third address byte and before any read-data byte completes. A non-FIFO read is one access of size N, and response byte k is `port_rdata[8k+7:8k]` (zero for k ≥ 4). FIFO read byte k is `port_rdata[7:0]` of access k.
- R6: During the first byte of a frame, and in the byte after every header, address or write-data byte, MISO carries 0x01. With pre-read off, read-data byte 0 carries 0x01 and read-data byte k ≥ 1 carries read byte k−1; the byte after the frame carries the last read byte.
- R7: With `pre_read` high, read-data byte k carries read byte k, and the byte after the frame carries 0xFF.
- R8: After a frame completes, every further byte in that chip-select window returns 0xFF and starts no port access.
- R9: Raising chip select before the last write byte aborts the frame: no port access is issued, and the next frame behaves normally.
- R10: SPI mode 0, MSB first: MOSI is sampled on rising SCLK, and MISO changes only while SCLK is low. MISO is 0 while the target is deselected.
- R11: Once `port_req` is raised, it and `port_addr`, `port_we` and `port_size` stay unchanged until a cycle with `port_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_read | input | 1 | 1 = advance read data one byte earlier |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| port_req | output | 1 | Register access request |
| port_we | output | 1 | 1 = write access |
| port_addr | output | 24 | Access address |
| port_size | output | 7 | Access size in bytes, 1 to 64 |
| port_wdata | output | 32 | Write data, byte 0 in bits [7:0] |
| port_ack | input | 1 | One-cycle completion of the current access |
| port_rdata | input | 32 | Read data, valid with port_ack |

## Verification
The bench probes the one-byte lag between a received byte and its response, in both pre-read settings and at length 1. In that case a design that miscounts the extra step returns stale or doubled data, or gives 0xFF too early or too late.

It runs a full 64-byte FIFO burst in each direction and uses a FIFO address with set upper address bits. A wrong mask or a wrong access count shows up there as a single wide access or a mis-ordered run.

An aborted write exposes any design that commits a half-filled buffer. A header with the reserved bit set catches a decoder that treats bit 6 as part of the length or the direction.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

   localparam int HDR_LEN_W = 6;
   localparam int MAX_LEN   = 1 << HDR_LEN_W;
   localparam int SIZE_W    = HDR_LEN_W + 1;

   localparam logic [7:0] RSP_BUSY = 8'h01;
   localparam logic [7:0] RSP_IDLE = 8'hFF;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_HDR,
      ST_ADR,
      ST_WR,
      ST_RD,
      ST_FETCH,
      ST_PUSH,
      ST_END
   } rb_state_e;

   function automatic logic hdr_is_read(input logic [7:0] h);
      return h[7];
   endfunction

   function automatic logic [HDR_LEN_W-1:0] hdr_len_m1(input logic [7:0] h);
      return h[HDR_LEN_W-1:0];
   endfunction

endpackage

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   input  logic [7:0] tx_byte,
   output logic       miso,
   output logic       sel,
   output logic       rx_valid,
   output logic [7:0] rx_byte
);

   logic [SYNC_STAGES-1:0] sclk_q, csn_q, mosi_q;
   logic       sclk_s, sclk_d, mosi_s, rise, fall;
   logic [2:0] bitcnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh;

   // synchronizer chain, one flop per stage
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               sclk_q[0] <= 1'b0; csn_q[0] <= 1'b1; mosi_q[0] <= 1'b0;
            end else begin
               sclk_q[0] <= sclk; csn_q[0] <= cs_n; mosi_q[0] <= mosi;
            end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               sclk_q[g] <= 1'b0; csn_q[g] <= 1'b1; mosi_q[g] <= 1'b0;
            end else begin
               sclk_q[g] <= sclk_q[g-1]; csn_q[g] <= csn_q[g-1]; mosi_q[g] <= mosi_q[g-1];
            end
      end
   end

   assign sclk_s = sclk_q[SYNC_STAGES-1];
   assign mosi_s = mosi_q[SYNC_STAGES-1];
   assign sel    = !csn_q[SYNC_STAGES-1];
   assign rise   = sel && sclk_s && !sclk_d;
   assign fall   = sel && !sclk_s && sclk_d;
   assign miso   = sel ? tx_sh[7] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         bitcnt   <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
      end else begin
         sclk_d   <= sclk_s;
         rx_valid <= 1'b0;
         if (!sel) begin
            bitcnt <= '0;
            tx_sh  <= tx_byte;
         end else if (rise) begin
            rx_sh  <= {rx_sh[5:0], mosi_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
               rx_valid <= 1'b1;
               rx_byte  <= {rx_sh, mosi_s};
            end
         end else if (fall && bitcnt != 3'd0) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
         end else if (bitcnt == 3'd0 && !sclk_s) begin
            tx_sh <= tx_byte;   // next response tracks the engine until the first edge
         end
      end
   end

   p_bitcnt_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> bitcnt == 3'd0);
   p_miso_hold_high_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      sel && sclk_s |=> $stable(tx_sh));

endmodule

// File: rtl/spi_rb_engine.sv
module spi_rb_engine
   import spi_rb_pkg::*;
#(
   parameter int          ADDR_W   = 24,
   parameter int          DATA_W   = 32,
   parameter logic [11:0] OFS_MASK = 12'hFFC,
   parameter logic [11:0] FIFO_OFS = 12'h024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              pre_read,
   output logic [7:0]        tx_byte,
   output logic              req,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic [SIZE_W-1:0] size,
   output logic [DATA_W-1:0] wdata,
   input  logic              ack,
   input  logic [DATA_W-1:0] rdata
);

   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int AC_W       = $clog2(ADDR_BYTES);
   localparam int DBYTES     = DATA_W / 8;

   rb_state_e             state;
   logic                  sel_d, rd_dir, is_fifo, last_acc;
   logic [HDR_LEN_W-1:0]  len_m1, idx, pidx;
   logic [AC_W-1:0]       acnt;
   logic [ADDR_W-1:0]     addr_r;
   logic [7:0]            dbuf [MAX_LEN];
   logic [DATA_W-1:0]     pack_w;

   for (genvar g = 0; g < DBYTES; g++) begin : g_pack
      assign pack_w[8*g +: 8] = dbuf[g];
   end

   assign is_fifo  = (addr_r[11:0] & OFS_MASK) == FIFO_OFS;
   assign last_acc = pidx == (is_fifo ? len_m1 : '0);
   assign req      = (state == ST_FETCH) || (state == ST_PUSH);
   assign we       = state == ST_PUSH;
   assign addr     = addr_r;
   assign size     = is_fifo ? SIZE_W'(1) : {1'b0, len_m1} + SIZE_W'(1);
   assign wdata    = is_fifo ? DATA_W'(dbuf[pidx]) : pack_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_OFF;
         sel_d   <= 1'b0;
         rd_dir  <= 1'b0;
         len_m1  <= '0;
         idx     <= '0;
         pidx    <= '0;
         acnt    <= '0;
         addr_r  <= '0;
         tx_byte <= RSP_IDLE;
         for (int k = 0; k < MAX_LEN; k++) dbuf[k] <= '0;
      end else begin
         sel_d <= sel;
         if (sel && !sel_d) begin
            state   <= ST_HDR;
            rd_dir  <= 1'b0;
            len_m1  <= '0;
            addr_r  <= '0;
            tx_byte <= RSP_BUSY;
            for (int k = 0; k < MAX_LEN; k++) dbuf[k] <= '0;
         end else if (req) begin
            if (ack) begin
               if (!we) begin
                  if (is_fifo) dbuf[pidx] <= rdata[7:0];
                  else for (int k = 0; k < DBYTES; k++) dbuf[k] <= rdata[8*k +: 8];
               end
               pidx <= pidx + 1'b1;
               if (last_acc) begin
                  if (we) begin
                     state <= ST_END;
                  end else if (pre_read) begin
                     tx_byte <= (pidx == '0) ? rdata[7:0] : dbuf[0];
                     idx     <= HDR_LEN_W'(1);
                     state   <= (len_m1 == '0) ? ST_END : ST_RD;
                  end else begin
                     idx   <= '0;
                     state <= ST_RD;
                  end
               end
            end
         end else if (!sel && state != ST_OFF) begin
            state <= ST_OFF;   // chip select gone: frame abandoned, nothing committed
         end else if (rx_valid) begin
            unique case (state)
               ST_HDR: begin
                  rd_dir  <= hdr_is_read(rx_byte);
                  len_m1  <= hdr_len_m1(rx_byte);
                  idx     <= '0;
                  acnt    <= '0;
                  tx_byte <= RSP_BUSY;
                  state   <= ST_ADR;
               end
               ST_ADR: begin
                  addr_r  <= {addr_r[ADDR_W-9:0], rx_byte};
                  acnt    <= acnt + 1'b1;
                  tx_byte <= RSP_BUSY;
                  if (acnt == AC_W'(ADDR_BYTES - 1)) begin
                     pidx  <= '0;
                     state <= rd_dir ? ST_FETCH : ST_WR;
                  end
               end
               ST_WR: begin
                  dbuf[idx] <= rx_byte;
                  idx       <= idx + 1'b1;
                  tx_byte   <= RSP_BUSY;
                  if (idx == len_m1) begin
                     pidx  <= '0;
                     state <= ST_PUSH;
                  end
               end
               ST_RD: begin
                  tx_byte <= dbuf[idx];
                  idx     <= idx + 1'b1;
                  if (idx == len_m1) state <= ST_END;
               end
               default: begin
                  tx_byte <= RSP_IDLE;
                  state   <= ST_OFF;
               end
            endcase
         end
      end
   end

   p_req_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack && sel |=> req && $stable(addr) && $stable(we) && $stable(size));
   p_write_after_byte_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) && we |-> $past(rx_valid));
   p_fetch_after_byte_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) && !we |-> $past(rx_valid));
   p_idle_resp_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && sel && sel_d && (state == ST_END || state == ST_OFF)
      |=> tx_byte == RSP_IDLE && !req);

endmodule

// File: rtl/spi_regbridge.sv
module spi_regbridge
   import spi_rb_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter int          ADDR_W      = 24,
   parameter int          DATA_W      = 32,
   parameter logic [11:0] OFS_MASK    = 12'hFFC,
   parameter logic [11:0] FIFO_OFS    = 12'h024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_read,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              port_req,
   output logic              port_we,
   output logic [ADDR_W-1:0] port_addr,
   output logic [SIZE_W-1:0] port_size,
   output logic [DATA_W-1:0] port_wdata,
   input  logic              port_ack,
   input  logic [DATA_W-1:0] port_rdata
);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W != 24) begin : g_chk_addr
      $error("ADDR_W must be 24: the frame carries three address bytes");
   end
   if (DATA_W < 8 || DATA_W % 8 != 0 || DATA_W > 8 * MAX_LEN) begin : g_chk_data
      $error("DATA_W must be a whole number of bytes, at most MAX_LEN");
   end

   logic       sel, rx_valid;
   logic [7:0] rx_byte, tx_byte;

   spi_rb_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (spi_sclk),
      .cs_n     (spi_cs_n),
      .mosi     (spi_mosi),
      .tx_byte  (tx_byte),
      .miso     (spi_miso),
      .sel      (sel),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte)
   );

   spi_rb_engine #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .OFS_MASK (OFS_MASK),
      .FIFO_OFS (FIFO_OFS)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .pre_read (pre_read),
      .tx_byte  (tx_byte),
      .req      (port_req),
      .we       (port_we),
      .addr     (port_addr),
      .size     (port_size),
      .wdata    (port_wdata),
      .ack      (port_ack),
      .rdata    (port_rdata)
   );

endmodule

// File: tb/spi_regbridge_tb.sv
module spi_regbridge_tb;

   localparam int HALF = 8;
   localparam int GAP  = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        pre_read = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso, req, we, ack;
   logic [23:0] addr;
   logic [6:0]  size;
   logic [31:0] wdata, rdata;

   int n_cmp = 0, n_bad = 0, seq = 0;
   bit quiet = 1'b0;

   typedef struct { bit we; logic [23:0] a; int sz; logic [31:0] wd; } acc_t;
   acc_t exp_q[$];
   logic [7:0] wq[$];

   spi_regbridge u_dut (
      .clk(clk), .rst_n(rst_n), .pre_read(pre_read),
      .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
      .port_req(req), .port_we(we), .port_addr(addr), .port_size(size),
      .port_wdata(wdata), .port_ack(ack), .port_rdata(rdata)
   );

   function automatic logic [31:0] mk_rdata(input logic [23:0] a, input int s);
      logic [31:0] r;
      for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'(s * 5 + k * 17) ^ a[7:0];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // register-port responder: one-cycle ack, data depends on access count
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0; rdata <= '0; seq <= 0;
      end else begin
         ack <= req && !ack;
         if (req && !ack) rdata <= mk_rdata(addr, seq);
         if (req && ack) seq <= seq + 1;
      end
   end

   // port monitor against the expected-access queue
   logic        stall_q = 1'b0;
   logic [23:0] a_q = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (stall_q) begin
            chk("R11 req held until ack", {31'b0, req}, 32'd1);
            chk("R11 addr held until ack", {8'b0, addr}, {8'b0, a_q});
         end
         stall_q = req && !ack;
         a_q = addr;
         if (req && quiet) chk("R3 no access before frame end", {31'b0, req}, 32'd0);
         if (req && ack) begin
            if (exp_q.size() == 0) begin
               chk("R8 unexpected port access", 32'd1, 32'd0);
            end else begin
               acc_t e;
               e = exp_q.pop_front();
               chk("R5 access direction", {31'b0, we}, {31'b0, e.we});
               chk("R2 access address", {8'b0, addr}, {8'b0, e.a});
               chk("R4 access size", {25'b0, size}, 32'(e.sz));
               if (e.we) chk("R3 write data", wdata, e.wd);
            end
         end
      end
   end

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         b = miso;
         rx[i] = b;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         chk("R10 miso stable while sclk high", {31'b0, miso}, {31'b0, b});
         sclk = 1'b0;
      end
   endtask

   task automatic run_frame(input bit rd, input int len, input logic [23:0] a,
                            input bit pre, input bit rsv);
      logic [7:0]  d [64];
      logic [7:0]  r, e;
      logic [31:0] w;
      bit          fifo;
      string       tg;
      fifo = ((a[11:0] & 12'hFFC) == 12'h024);
      pre_read = pre;
      if (rd) begin
         if (fifo) begin
            for (int i = 0; i < len; i++) begin
               w = mk_rdata(a, seq + i);
               d[i] = w[7:0];
               exp_q.push_back('{1'b0, a, 1, 32'd0});
            end
         end else begin
            w = mk_rdata(a, seq);
            for (int i = 0; i < len; i++) d[i] = (i < 4) ? w[8*i +: 8] : 8'h00;
            exp_q.push_back('{1'b0, a, len, 32'd0});
         end
      end else begin
         if (fifo) begin
            for (int i = 0; i < len; i++) exp_q.push_back('{1'b1, a, 1, {24'b0, wq[i]}});
         end else begin
            w = '0;
            for (int i = 0; i < len && i < 4; i++) w[8*i +: 8] = wq[i];
            exp_q.push_back('{1'b1, a, len, w});
         end
      end
      @(negedge clk);
      cs_n = 1'b0;
      quiet = 1'b1;
      repeat (2 * HALF) @(negedge clk);
      xfer({rd, rsv, 6'(len - 1)}, r);
      chk("R6 first byte response R1 header", {24'b0, r}, 32'h01);
      for (int k = 0; k < 3; k++) begin
         if (rd && k == 2) quiet = 1'b0;
         xfer(a[23 - 8*k -: 8], r);
         chk("R6 address phase response", {24'b0, r}, 32'h01);
      end
      if (rd) repeat (GAP) @(negedge clk);
      for (int j = 0; j < len; j++) begin
         if (!rd && j == len - 1) quiet = 1'b0;
         xfer(rd ? 8'h00 : wq[j], r);
         if (!rd)     begin e = 8'h01; tg = "R6 write data response"; end
         else if (pre) begin e = d[j]; tg = "R7 pre-read data"; end
         else begin e = (j == 0) ? 8'h01 : d[j-1]; tg = "R5 read data lagged one byte"; end
         chk(tg, {24'b0, r}, {24'b0, e});
      end
      if (!rd) repeat (GAP) @(negedge clk);
      xfer(8'hA5, r);
      e = !rd ? 8'h01 : (pre ? 8'hFF : d[len-1]);
      chk(pre && rd ? "R7 byte after frame" : "R6 byte after frame", {24'b0, r}, {24'b0, e});
      xfer(8'h5A, r);
      chk("R8 done state returns FF", {24'b0, r}, 32'hFF);
      xfer(8'h3C, r);
      chk("R8 stays deactivated", {24'b0, r}, 32'hFF);
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
      chk("R10 miso low when deselected", {31'b0, miso}, 32'd0);
      chk("R3 all expected accesses seen", 32'(exp_q.size()), 32'd0);
      exp_q.delete();
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      logic [7:0] r;
      int s0;
      repeat (5) @(negedge clk);
      chk("R10 reset miso", {31'b0, miso}, 32'd0);
      chk("R11 reset req", {31'b0, req}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      wq = '{8'h3E};
      run_frame(1'b0, 1, 24'h000010, 1'b0, 1'b0);
      wq = '{8'h11, 8'h22, 8'h33, 8'h44};
      run_frame(1'b0, 4, 24'h000014, 1'b0, 1'b1);      // R1 reserved bit set
      run_frame(1'b1, 1, 24'h000010, 1'b0, 1'b0);
      run_frame(1'b1, 4, 24'hABC018, 1'b0, 1'b0);
      run_frame(1'b1, 4, 24'h000018, 1'b1, 1'b1);      // R7 with R1 reserved bit
      run_frame(1'b1, 1, 24'h00002C, 1'b1, 1'b0);
      run_frame(1'b1, 6, 24'h000030, 1'b0, 1'b0);      // R5 bytes past 4 read as zero
      wq.delete();
      for (int i = 0; i < 64; i++) wq.push_back(8'(i * 7 + 3));
      run_frame(1'b0, 64, 24'h000024, 1'b0, 1'b0);     // R4 FIFO write burst
      run_frame(1'b1, 64, 24'h123024, 1'b0, 1'b0);     // R4 FIFO read burst
      run_frame(1'b1, 8, 24'h000027, 1'b1, 1'b0);      // R4 masked offset, R7
      run_frame(1'b1, 1, 24'h000025, 1'b1, 1'b0);

      // R9: abort a write after two of four data bytes
      s0 = seq;
      @(negedge clk);
      cs_n = 1'b0;
      quiet = 1'b1;
      repeat (2 * HALF) @(negedge clk);
      xfer(8'h03, r);
      xfer(8'h00, r); xfer(8'h00, r); xfer(8'h40, r);
      xfer(8'hDE, r); xfer(8'hAD, r);
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (GAP) @(negedge clk);
      quiet = 1'b0;
      chk("R9 aborted write issued no access", 32'(seq), 32'(s0));
      wq = '{8'h5C, 8'hC5};
      run_frame(1'b0, 2, 24'h000040, 1'b0, 1'b0);      // R9 next frame works
      run_frame(1'b1, 2, 24'h000040, 1'b1, 1'b0);

      finish_run();
   end

endmodule